// File: doc/BRIEF.md
# Excluding Random Tag Generator

This block produces 4-bit allocation tags for a memory-tagging scheme. A generate request carries a 16-bit exclusion mask, a flag that allows random reseeding, and a 24-bit state word that packs a start tag and a 16-bit seed. The block steps a 16-bit linear feedback shift register four times to form a 4-bit offset. It then walks the tag space upward from the start tag, skipping every excluded value, and returns the tag it lands on together with a rewritten state word.

An adjust request uses the same walker without the shift register. It starts from a tag taken from a pointer, counts a caller-given offset, and applies only the control-register exclusion mask. Both request kinds enter through a single valid/ready handshake. The walk takes one cycle per tag increment, and a one-cycle done pulse presents the result.

Top module: `excltag_gen`

## Requirements
- R1: `req_ready` is high after reset and whenever no request is in flight. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the result is presented, and `done` is high for exactly one cycle per accepted request.
- R2: For a generate request (`req_kind`=0), the effective exclusion mask is `req_mask | ctl_mask`. Bit k set means tag value k is never returned.
- R3: If all 16 bits of the effective exclusion mask are set, the result tag is 0.
- R4: With offset 0, the result is the first non-excluded tag at or after the start tag, counting upward modulo 16.
- R5: With offset n>0, the result is the n-th non-excluded tag strictly after the start tag, counting upward modulo 16.
- R6: In the state word, bits [3:0] hold the start tag and bits [23:8] hold the seed.
- R7: One shift-register step computes feedback = s[5]^s[3]^s[2]^s[0], shifts the seed right by one and inserts the feedback at bit 15. A generate request takes four steps, and bit i of the offset is bit 0 of the seed after step i+1.
- R8: After a generate request, `state_out` holds the stepped seed in [23:8], zero in [7:4] and the result tag in [3:0].
- R9: If the seed is zero and `rand_en` is 1, stepping starts from `entropy` when that input is non-zero, and from 16'hB5A3 otherwise. If the seed is zero and `rand_en` is 0, the seed stays zero and the offset is 0.
- R10: For an adjust request (`req_kind`=1), the start tag is `ptr_tag`, the mask is `ctl_mask` alone (`req_mask` has no effect), the offset is `req_offset`, and `state_out` equals `state_in` unchanged.
- R11: The walk takes at most 16 increments per offset unit, so `done` follows acceptance within 16*(offset+1)+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_kind | input | 1 | 0 = generate, 1 = adjust |
| req_mask | input | 16 | Per-request exclusion mask (generate only) |
| ctl_mask | input | 16 | Control-register exclusion mask |
| rand_en | input | 1 | Allows reseeding from a zero seed |
| state_in | input | 24 | State word: seed [23:8], start tag [3:0] |
| ptr_tag | input | 4 | Start tag for adjust requests |
| req_offset | input | 4 | Offset for adjust requests |
| entropy | input | 16 | Replacement seed source |
| done | output | 1 | One-cycle result strobe |
| tag_out | output | 4 | Chosen tag, valid with done |
| state_out | output | 24 | Updated state word, valid with done |

## Verification
The assertions check on every cycle that a finished walk never lands on an excluded tag, that a fully excluded mask yields tag 0, that no offset unit takes more than 16 increments, that done lasts one cycle with the block ready again, and that the returned state word carries the result tag with a live seed whenever reseeding was allowed. Only the bench scenarios can show that the exact tag is the correct n-th survivor, that the shift register produces the right offset bits and seed, that an adjust request ignores the per-request mask and passes the state through, and that the zero-seed fallbacks choose the right source.

// File: rtl/excltag_pkg.sv
package excltag_pkg;
  typedef enum logic {
    KIND_GEN = 1'b0,
    KIND_ADJ = 1'b1
  } req_kind_e;

  typedef enum logic {
    W_IDLE = 1'b0,
    W_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/excltag_lfsr.sv
module excltag_lfsr #(
  parameter int SEED_W = 16,
  parameter logic [SEED_W-1:0] TAPS = 16'h002D,
  parameter int STEPS = 4
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic [STEPS-1:0]  bits_o
);
  logic [SEED_W-1:0] chain [STEPS+1];

  assign chain[0] = seed_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb           = ^(chain[g] & TAPS);
    assign chain[g+1]   = {fb, chain[g][SEED_W-1:1]};
    assign bits_o[g]    = chain[g+1][0];
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/excltag_walker.sv
module excltag_walker
  import excltag_pkg::*;
#(
  parameter int TAG_W = 4,
  localparam int NT = 1 << TAG_W,
  localparam int CNT_W = $clog2(NT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [TAG_W-1:0] start_i,
  input  logic [NT-1:0]    mask_i,
  input  logic [TAG_W-1:0] off_i,
  output logic             fin_o,
  output logic [TAG_W-1:0] res_o
);
  walk_st_e         st;
  logic [TAG_W-1:0] cur, rem, nxt;
  logic [NT-1:0]    mask_q;
  logic [CNT_W-1:0] unit_cnt;
  logic             fin_q;
  logic [TAG_W-1:0] res_q;

  assign nxt = cur + TAG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= W_IDLE;
      cur      <= '0;
      rem      <= '0;
      mask_q   <= '0;
      unit_cnt <= '0;
      fin_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      fin_q <= 1'b0;
      case (st)
        W_IDLE: begin
          if (go_i) begin
            mask_q   <= mask_i;
            cur      <= start_i;
            rem      <= off_i;
            unit_cnt <= '0;
            if (&mask_i) begin
              fin_q <= 1'b1;
              res_q <= '0;
            end else begin
              st <= W_WALK;
            end
          end
        end
        W_WALK: begin
          if (rem == '0) begin
            if (mask_q[cur]) begin
              cur      <= nxt;
              unit_cnt <= unit_cnt + CNT_W'(1);
            end else begin
              fin_q <= 1'b1;
              res_q <= cur;
              st    <= W_IDLE;
            end
          end else begin
            cur <= nxt;
            if (mask_q[nxt]) begin
              unit_cnt <= unit_cnt + CNT_W'(1);
            end else begin
              unit_cnt <= '0;
              rem      <= rem - TAG_W'(1);
              if (rem == TAG_W'(1)) begin
                fin_q <= 1'b1;
                res_q <= nxt;
                st    <= W_IDLE;
              end
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign fin_o = fin_q;
  assign res_o = res_q;

  // R11: each offset unit finds a free tag within NT increments
  p_unit_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (st == W_WALK) |-> (unit_cnt < CNT_W'(NT)));

  // R4 / R5: a finished walk never lands on an excluded tag
  p_result_free_r4: assert property (@(posedge clk) disable iff (rst)
    (fin_q && !(&mask_q)) |-> !mask_q[res_q]);

  // R3: fully excluded mask gives tag 0
  p_all_excl_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (fin_q && (&mask_q)) |-> (res_q == '0));

  // R1: a new walk only starts when idle
  p_go_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
    go_i |-> (st == W_IDLE));
endmodule

// File: rtl/excltag_gen.sv
module excltag_gen
  import excltag_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int SEED_W   = 16,
  parameter int SEED_LSB = 8,
  parameter int STATE_W  = 24,
  parameter logic [SEED_W-1:0] TAPS     = 16'h002D,
  parameter logic [SEED_W-1:0] FALLBACK = 16'hB5A3,
  localparam int NT = 1 << TAG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_kind,
  input  logic [NT-1:0]      req_mask,
  input  logic [NT-1:0]      ctl_mask,
  input  logic               rand_en,
  input  logic [STATE_W-1:0] state_in,
  input  logic [TAG_W-1:0]   ptr_tag,
  input  logic [TAG_W-1:0]   req_offset,
  input  logic [SEED_W-1:0]  entropy,
  output logic               done,
  output logic [TAG_W-1:0]   tag_out,
  output logic [STATE_W-1:0] state_out
);
  logic              busy_q;
  logic              accept;
  req_kind_e         kind_in, kind_q;
  logic              rand_q;
  logic [SEED_W-1:0] seed_in, seed_eff, seed_new;
  logic [TAG_W-1:0]  lfsr_off;
  logic [TAG_W-1:0]  w_start, w_off;
  logic [NT-1:0]     w_mask;
  logic [STATE_W-1:0] gen_state, pend_q;
  logic              w_fin;
  logic [TAG_W-1:0]  w_res;

  assign kind_in   = req_kind_e'(req_kind);
  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;

  assign seed_in = state_in[SEED_LSB +: SEED_W];

  always_comb begin
    seed_eff = seed_in;
    if (seed_in == '0 && rand_en) begin
      seed_eff = (entropy != '0) ? entropy : FALLBACK;
    end
  end

  excltag_lfsr #(
    .SEED_W(SEED_W),
    .TAPS  (TAPS),
    .STEPS (TAG_W)
  ) u_lfsr (
    .seed_i(seed_eff),
    .seed_o(seed_new),
    .bits_o(lfsr_off)
  );

  always_comb begin
    if (kind_in == KIND_ADJ) begin
      w_start = ptr_tag;
      w_mask  = ctl_mask;
      w_off   = req_offset;
    end else begin
      w_start = state_in[TAG_W-1:0];
      w_mask  = req_mask | ctl_mask;
      w_off   = lfsr_off;
    end
  end

  always_comb begin
    gen_state = '0;
    gen_state[SEED_LSB +: SEED_W] = seed_new;
  end

  excltag_walker #(
    .TAG_W(TAG_W)
  ) u_walker (
    .clk    (clk),
    .rst    (rst),
    .go_i   (accept),
    .start_i(w_start),
    .mask_i (w_mask),
    .off_i  (w_off),
    .fin_o  (w_fin),
    .res_o  (w_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      kind_q    <= KIND_GEN;
      rand_q    <= 1'b0;
      pend_q    <= '0;
      done      <= 1'b0;
      tag_out   <= '0;
      state_out <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        kind_q <= kind_in;
        rand_q <= rand_en;
        pend_q <= (kind_in == KIND_ADJ) ? state_in : gen_state;
      end
      if (w_fin) begin
        busy_q  <= 1'b0;
        done    <= 1'b1;
        tag_out <= w_res;
        if (kind_q == KIND_GEN) begin
          state_out <= pend_q | STATE_W'(w_res);
        end else begin
          state_out <= pend_q;
        end
      end
    end
  end

  // R1: result strobe lasts one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: block is ready again when the result appears
  p_ready_at_done_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R8: generate result carries the tag in the low field and zero above it
  p_gen_state_tag_r8: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == KIND_GEN) |->
      (state_out[TAG_W-1:0] == tag_out) && (state_out[SEED_LSB-1:TAG_W] == '0));

  // R9: with reseeding allowed the returned seed is never zero
  p_seed_alive_r9: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == KIND_GEN && rand_q) |->
      (state_out[SEED_LSB +: SEED_W] != '0));
endmodule

// File: tb/excltag_gen_tb.sv
`timescale 1ns/1ps
module excltag_gen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_kind;
  logic [15:0] req_mask, ctl_mask;
  logic        rand_en;
  logic [23:0] state_in;
  logic [3:0]  ptr_tag, req_offset;
  logic [15:0] entropy;
  logic        done;
  logic [3:0]  tag_out;
  logic [23:0] state_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  excltag_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_mask(req_mask), .ctl_mask(ctl_mask),
    .rand_en(rand_en), .state_in(state_in), .ptr_tag(ptr_tag),
    .req_offset(req_offset), .entropy(entropy), .done(done),
    .tag_out(tag_out), .state_out(state_out)
  );

  function automatic logic [15:0] step_seed(input logic [15:0] s);
    logic fb;
    fb = s[5] ^ s[3] ^ s[2] ^ s[0];
    return {fb, s[15:1]};
  endfunction

  function automatic logic [3:0] pick_tag(input logic [3:0] start,
                                          input logic [3:0] off,
                                          input logic [15:0] m);
    logic [3:0] t;
    if (m == 16'hFFFF) return 4'd0;
    t = start;
    if (off == 0) begin
      while (m[t]) t = t + 4'd1;
    end else begin
      for (int u = 0; u < off; u++) begin
        t = t + 4'd1;
        while (m[t]) t = t + 4'd1;
      end
    end
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic kind, input logic [15:0] rmask,
                         input logic [15:0] cmask, input logic ren,
                         input logic [23:0] st, input logic [3:0] ptag,
                         input logic [3:0] off, input logic [15:0] ent,
                         input string req);
    logic [15:0] seed, m;
    logic [3:0]  o, start, etag;
    logic [23:0] est;
    int cyc;
    if (kind == 1'b1) begin
      start = ptag; m = cmask; o = off; est = st;
      etag = pick_tag(start, o, m);
    end else begin
      seed = st[23:8];
      if (seed == 0 && ren) seed = (ent != 0) ? ent : 16'hB5A3;
      for (int i = 0; i < 4; i++) begin
        seed = step_seed(seed);
        o[i] = seed[0];
      end
      start = st[3:0]; m = rmask | cmask;
      etag = pick_tag(start, o, m);
      est = {seed, 4'b0000, etag};
    end
    @(negedge clk);
    req_kind = kind; req_mask = rmask; ctl_mask = cmask; rand_en = ren;
    state_in = st; ptr_tag = ptag; req_offset = off; entropy = ent;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready low while busy", {31'd0, req_ready}, 32'd0);
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R11", "done within bound", cyc, 16 * (o + 1) + 3);
    check(cyc <= 16 * (o + 1) + 3, "R11", "latency", cyc, 16 * (o + 1) + 3);
    check(tag_out == etag, req, "tag", {28'd0, tag_out}, {28'd0, etag});
    check(state_out == est, req, "state", {8'd0, state_out}, {8'd0, est});
    @(negedge clk);
    check(done == 1'b0, "R1", "single done pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_kind = 1'b0; req_mask = '0;
    ctl_mask = '0; rand_en = 1'b0; state_in = '0; ptr_tag = '0;
    req_offset = '0; entropy = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    check(done == 1'b0, "R1", "done low after reset", {31'd0, done}, 32'd0);

    // R3: every tag excluded, via the two masks together
    run_req(1'b0, 16'hFF00, 16'h00FF, 1'b0, 24'h12_34_05, 4'd0, 4'd0, 16'd0, "R3");
    run_req(1'b1, 16'h0000, 16'hFFFF, 1'b0, 24'hABCDEF, 4'd9, 4'd7, 16'd0, "R3");
    // R4: zero offset, excluded start, wrap past 15
    run_req(1'b1, 16'h0000, 16'hC001, 1'b0, 24'h000000, 4'd14, 4'd0, 16'd0, "R4");
    run_req(1'b1, 16'h0000, 16'h0000, 1'b0, 24'h000000, 4'd6, 4'd0, 16'd0, "R4");
    // R5: offset walks with wrap and single free tag
    run_req(1'b1, 16'h0000, 16'hFFF7, 1'b0, 24'h000000, 4'd3, 4'd15, 16'd0, "R5");
    run_req(1'b1, 16'h0000, 16'h5555, 1'b0, 24'h000000, 4'd13, 4'd3, 16'd0, "R5");
    // R10: req_mask all ones must have no effect on an adjust request
    run_req(1'b1, 16'hFFFF, 16'h0000, 1'b0, 24'h5A5A5A, 4'd2, 4'd1, 16'd0, "R10");
    // R2: request mask alone excludes the natural result
    run_req(1'b0, 16'h00F0, 16'h0000, 1'b0, 24'h000104, 4'd0, 4'd0, 16'd0, "R2");
    // R6/R7: known seed, start tag in low field
    run_req(1'b0, 16'h0000, 16'h0000, 1'b0, 24'hACE109, 4'd0, 4'd0, 16'd0, "R7");
    run_req(1'b0, 16'h0000, 16'h0000, 1'b0, 24'h0001_0C, 4'd0, 4'd0, 16'd0, "R6");
    // R9: zero seed cases
    run_req(1'b0, 16'h0000, 16'h0000, 1'b1, 24'h000003, 4'd0, 4'd0, 16'h1234, "R9");
    run_req(1'b0, 16'h0000, 16'h0000, 1'b1, 24'h000003, 4'd0, 4'd0, 16'h0000, "R9");
    run_req(1'b0, 16'h0000, 16'h0010, 1'b0, 24'h0000F4, 4'd0, 4'd0, 16'hBEEF, "R9");
    // R8: state rewrite with dirty [7:4] on input
    run_req(1'b0, 16'h1111, 16'h0000, 1'b0, 24'h7777F7, 4'd0, 4'd0, 16'd0, "R8");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] rm, cm;
      logic [23:0] st;
      rm = 16'($urandom) & 16'($urandom);
      cm = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom) & 16'($urandom);
      st = 24'($urandom);
      if ($urandom % 8 == 0) st[23:8] = 16'd0;
      run_req(1'($urandom), rm, cm, 1'($urandom), st, 4'($urandom),
              4'($urandom), ($urandom % 3 == 0) ? 16'd0 : 16'($urandom),
              "R5");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule